// File: doc/BRIEF.md
# Receive Control-Frame Filter with Pause Timer

This block sits on the byte stream of an Ethernet receive path, between the deserializer and the frame buffer. It watches each frame's leading bytes and compares the destination address against a configurable number of station address slots (two by default). For every slot it uses three settings: the address, an accept bit, and a flow-control enable bit. A single global pause-forward bit completes the configuration. The block spots MAC Control frames (EtherType 0x8808) and, among them, pause requests (opcode 0x0001). At each frame end it produces a one-cycle forward/discard verdict.

When an accepted pause request arrives on a slot with flow control enabled, the block loads the request's 16-bit quanta into a countdown. The countdown drops by one on every quantum tick (one tick per 512 bit times). While it is nonzero, the transmit side is told to hold off. Flow control works whether or not pause frames are forwarded. On a slot with flow control disabled, control frames are treated like any other frame. Everything, including the configuration path that feeds it, is cleared only by the dedicated receive reset. Address filtering therefore keeps running while the system bus side is held in reset.

The input is a valid/ready byte stream. The block never applies back-pressure: `in_ready` is low only during receive reset and in the first cycle after it, and is high from then on. Bytes count only on cycles where `in_valid` and `in_ready` are both high. The verdict and pause outputs are plain status pins with no handshake.

Top module: `mac_ctl_rx_filter`

## Requirements
- R1: While `rx_rst_n` is low, `verdict_valid`, `pause_count` and `tx_pause` are 0 and `in_ready` is 0. From the first rising clock edge with `rx_rst_n` high onward, `in_ready` is 1.
- R2: Bytes 0 to 5 of a frame are its destination address, and byte 0 is compared with bits 47:40 of a slot address. A slot passes when all six bytes match and its bit in `slot_accept` is 1. A frame that no slot passes, including a frame shorter than 6 bytes, gets `verdict_fwd` = 0 and never loads the pause timer.
- R3: When several slots pass, the lowest-numbered one is the matched slot, and only its bit in `slot_fc_en` takes effect.
- R4: A frame is a control frame only if it is at least 18 bytes long and bytes 12 to 13 equal 0x8808. It is a pause frame if, in addition, bytes 14 to 15 equal 0x0001. A frame that passes the address check but is shorter than 18 bytes is always forwarded.
- R5: When the matched slot has flow control enabled and `pause_accept` is 0, a pause frame gets `verdict_fwd` = 0. Any other control frame, and any other frame, gets `verdict_fwd` = 1.
- R6: When the matched slot has flow control enabled and `pause_accept` is 1, every frame that passes the address check is forwarded, and pause frames still load the timer.
- R7: When the matched slot has flow control disabled, every frame that passes the address check is forwarded, whatever `pause_accept` is, and nothing loads the timer.
- R8: `verdict_valid` is high for exactly the one cycle that follows the clock edge which accepted the frame's `in_eof` byte. It is high at no other time. `verdict_fwd` is meaningful in that cycle.
- R9: A pause frame that passes the address check on a slot with flow control enabled, and ends without `in_err`, loads bytes 16 to 17 (byte 16 as the high byte) into `pause_count`. The load takes place at the edge that ends the `verdict_valid` cycle. It overwrites any remaining count, and a quanta of zero cancels the pause.
- R10: With no load, `pause_count` decreases by 1 at each edge where `quantum_tick` is 1 and the count is nonzero, and otherwise holds. A load takes precedence over a tick at the same edge. `tx_pause` is 1 exactly when `pause_count` is nonzero.
- R11: An `in_err` flag on the last byte blocks the pause load but does not change `verdict_fwd`.
- R12: Cycles with `in_valid` low in the middle of a frame have no effect: the verdict and the pause load are the same as for the same bytes sent without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rx_rst_n | input | 1 | Dedicated receive reset, active low, asynchronous assert |
| slot_addr | input | N_SLOTS x 48 | Station address per slot, bits 47:40 compared with frame byte 0 |
| slot_accept | input | N_SLOTS | Per-slot address accept enable |
| slot_fc_en | input | N_SLOTS | Per-slot receive flow-control enable |
| pause_accept | input | 1 | Forward pause frames to the host when 1 |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte ready (high after reset, no back-pressure) |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_err | input | 1 | Frame error flag, sampled with the last byte |
| quantum_tick | input | 1 | One pulse per 512 bit times |
| verdict_valid | output | 1 | One-cycle pulse carrying the frame verdict |
| verdict_fwd | output | 1 | 1 = forward to host, 0 = discard |
| pause_count | output | 16 | Remaining pause quanta |
| tx_pause | output | 1 | Transmit hold-off request |

## Verification
The bench sends frames that isolate each branch of the decision:
- pause requests and other control opcodes on a slot with flow control on, with `pause_accept` both clear and set, which separates dropping a frame from forwarding it while the pause still acts;
- the same frames on a slot with flow control off, where the timer must not move;
- destination addresses that match no slot, or match a slot that is not accepted, which checks address filtering apart from control detection;
- an address present in both slots, which shows which slot's flow-control bit rules;
- frames of 1, 5 and 16 bytes, which check that header detection is gated by length;
- frames with an error flag, which separate the verdict from the timer load;
- frames with idle gaps and frames sent back to back, which check that byte counting is tied to the handshake and not to clock cycles.

Tick rates of never, every cycle and every third cycle, and quanta of zero, show countdown, overwrite, cancel, and a load winning over a tick on the same edge.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int TYPE_POS   = 12;
  localparam int OPC_POS    = 14;
  localparam int QNT_POS    = 16;
  localparam int HDR_BYTES  = 18;
  localparam int IDX_W      = $clog2(HDR_BYTES + 1);

  localparam logic [15:0] CTL_ETYPE = 16'h8808;
  localparam logic [15:0] PAUSE_OPC = 16'h0001;

  typedef logic [IDX_W-1:0] idx_t;

  typedef struct packed {
    logic        da_seen;
    logic        is_ctl;
    logic        is_pause;
    logic [15:0] quanta;
    logic        err;
  } hdr_t;
endpackage

// File: rtl/mcf_hdr_parse.sv
module mcf_hdr_parse
  import mcf_pkg::*;
#(
  parameter int N_SLOTS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     beat,
  input  logic                     sof,
  input  logic                     eof,
  input  logic                     err,
  input  logic [7:0]               data,
  input  logic [N_SLOTS-1:0][47:0] slot_addr,
  output logic [N_SLOTS-1:0]       hit,
  output hdr_t                     hdr,
  output logic                     done
);
  localparam idx_t DA_END  = idx_t'(ADDR_BYTES);
  localparam idx_t HDR_END = idx_t'(HDR_BYTES);
  localparam idx_t T_HI = idx_t'(TYPE_POS);
  localparam idx_t T_LO = idx_t'(TYPE_POS + 1);
  localparam idx_t O_HI = idx_t'(OPC_POS);
  localparam idx_t O_LO = idx_t'(OPC_POS + 1);
  localparam idx_t Q_HI = idx_t'(QNT_POS);
  localparam idx_t Q_LO = idx_t'(QNT_POS + 1);

  idx_t        idx_q;
  idx_t        pos;
  logic [15:0] etype_q, opc_q, qnt_q;
  logic        err_q, done_q;

  // position of the byte on the bus; a start marker restarts the count
  assign pos = sof ? '0 : idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      etype_q <= '0;
      opc_q   <= '0;
      qnt_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= beat && eof;
      if (beat) begin
        idx_q <= (pos == HDR_END) ? pos : pos + idx_t'(1);
        case (pos)
          T_HI: etype_q[15:8] <= data;
          T_LO: etype_q[7:0]  <= data;
          O_HI: opc_q[15:8]   <= data;
          O_LO: opc_q[7:0]    <= data;
          Q_HI: qnt_q[15:8]   <= data;
          Q_LO: qnt_q[7:0]    <= data;
          default: ;
        endcase
        if (eof) err_q <= err;
      end
    end
  end

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    logic [7:0] exp_b;
    logic       hit_q;

    always_comb begin
      exp_b = '0;
      for (int k = 0; k < ADDR_BYTES; k++)
        if (pos == idx_t'(k)) exp_b = slot_addr[s][8*(ADDR_BYTES-1-k) +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_q <= 1'b0;
      else if (beat && (pos < DA_END))
        hit_q <= (sof | hit_q) & (data == exp_b);
    end

    assign hit[s] = hit_q;
  end

  always_comb begin
    hdr.da_seen  = (idx_q >= DA_END);
    hdr.is_ctl   = (idx_q == HDR_END) && (etype_q == CTL_ETYPE);
    hdr.is_pause = hdr.is_ctl && (opc_q == PAUSE_OPC);
    hdr.quanta   = qnt_q;
    hdr.err      = err_q;
  end

  assign done = done_q;
endmodule

// File: rtl/mcf_decide.sv
module mcf_decide
  import mcf_pkg::*;
#(
  parameter int N_SLOTS = 2
) (
  input  logic               valid,
  input  logic [N_SLOTS-1:0] hit,
  input  hdr_t               hdr,
  input  logic [N_SLOTS-1:0] accept,
  input  logic [N_SLOTS-1:0] fc_en,
  input  logic               pause_accept,
  output logic               pass_any,
  output logic               sel_fc,
  output logic               fwd,
  output logic               load
);
  // lowest passing slot wins: scan downward so the last write is the lowest
  always_comb begin
    pass_any = 1'b0;
    sel_fc   = 1'b0;
    for (int s = N_SLOTS - 1; s >= 0; s--) begin
      if (hit[s] && accept[s] && hdr.da_seen) begin
        pass_any = 1'b1;
        sel_fc   = fc_en[s];
      end
    end
  end

  always_comb begin
    fwd  = pass_any && !(sel_fc && hdr.is_pause && !pause_accept);
    load = valid && pass_any && sel_fc && hdr.is_pause && !hdr.err;
  end
endmodule

// File: rtl/mcf_pause_timer.sv
module mcf_pause_timer #(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [QW-1:0] quanta,
  input  logic          tick,
  output logic [QW-1:0] count,
  output logic          active
);
  logic [QW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (load)                     cnt_q <= quanta;
    else if (tick && (cnt_q != '0))    cnt_q <= cnt_q - QW'(1);
  end

  assign count  = cnt_q;
  assign active = (cnt_q != '0);
endmodule

// File: rtl/mac_ctl_rx_filter.sv
module mac_ctl_rx_filter
  import mcf_pkg::*;
#(
  parameter int N_SLOTS = 2,
  parameter int QW      = 16
) (
  input  logic                     clk,
  input  logic                     rx_rst_n,
  input  logic [N_SLOTS-1:0][47:0] slot_addr,
  input  logic [N_SLOTS-1:0]       slot_accept,
  input  logic [N_SLOTS-1:0]       slot_fc_en,
  input  logic                     pause_accept,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [7:0]               in_data,
  input  logic                     in_sof,
  input  logic                     in_eof,
  input  logic                     in_err,
  input  logic                     quantum_tick,
  output logic                     verdict_valid,
  output logic                     verdict_fwd,
  output logic [QW-1:0]            pause_count,
  output logic                     tx_pause
);
  logic               rdy_q;
  logic               beat;
  logic [N_SLOTS-1:0] hit;
  hdr_t               hdr;
  logic               done;
  logic               pass_any, sel_fc, fwd, load;

  always_ff @(posedge clk or negedge rx_rst_n) begin
    if (!rx_rst_n) rdy_q <= 1'b0;
    else           rdy_q <= 1'b1;
  end

  assign in_ready = rdy_q;
  assign beat     = in_valid && rdy_q;

  mcf_hdr_parse #(.N_SLOTS(N_SLOTS)) u_parse (
    .clk       (clk),
    .rst_n     (rx_rst_n),
    .beat      (beat),
    .sof       (in_sof),
    .eof       (in_eof),
    .err       (in_err),
    .data      (in_data),
    .slot_addr (slot_addr),
    .hit       (hit),
    .hdr       (hdr),
    .done      (done)
  );

  mcf_decide #(.N_SLOTS(N_SLOTS)) u_decide (
    .valid        (done),
    .hit          (hit),
    .hdr          (hdr),
    .accept       (slot_accept),
    .fc_en        (slot_fc_en),
    .pause_accept (pause_accept),
    .pass_any     (pass_any),
    .sel_fc       (sel_fc),
    .fwd          (fwd),
    .load         (load)
  );

  mcf_pause_timer #(.QW(QW)) u_timer (
    .clk    (clk),
    .rst_n  (rx_rst_n),
    .load   (load),
    .quanta (QW'(hdr.quanta)),
    .tick   (quantum_tick),
    .count  (pause_count),
    .active (tx_pause)
  );

  assign verdict_valid = done;
  assign verdict_fwd   = done && fwd;
endmodule

// File: rtl/mcf_rx_filter_chk.sv
module mcf_rx_filter_chk #(
  parameter int QW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_eof,
  input logic          verdict_valid,
  input logic          verdict_fwd,
  input logic          tick,
  input logic [QW-1:0] pause_count,
  input logic          pass_any,
  input logic          sel_fc,
  input logic          hdr_pause,
  input logic          hdr_err,
  input logic          pause_accept
);
  p_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> in_ready);

  p_nomatch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid && !pass_any |-> !verdict_fwd);

  p_drop_pause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid && pass_any && sel_fc && hdr_pause && !pause_accept |-> !verdict_fwd);

  p_accept_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid && pass_any && pause_accept |-> verdict_fwd);

  p_no_fc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid && pass_any && !sel_fc |-> verdict_fwd);

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> $past(in_valid && in_ready && in_eof));

  p_count_dec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_valid && tick && (pause_count != '0) |=> pause_count == $past(pause_count) - QW'(1));

  p_count_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_valid && !tick |=> $stable(pause_count));

  p_err_noload_r11: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid && hdr_err && !tick |=> $stable(pause_count));
endmodule

bind mac_ctl_rx_filter mcf_rx_filter_chk #(.QW(QW)) u_chk (
  .clk           (clk),
  .rst_n         (rx_rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_eof        (in_eof),
  .verdict_valid (verdict_valid),
  .verdict_fwd   (verdict_fwd),
  .tick          (quantum_tick),
  .pause_count   (pause_count),
  .pass_any      (pass_any),
  .sel_fc        (sel_fc),
  .hdr_pause     (hdr.is_pause),
  .hdr_err       (hdr.err),
  .pause_accept  (pause_accept)
);

// File: tb/sim_mac_ctl_rx_filter.sv
`timescale 1ns/1ps
module sim_mac_ctl_rx_filter;
  localparam int PERIOD = 10;
  localparam int NS = 2;

  logic               clk = 1'b0;
  logic               rx_rst_n = 1'b0;
  logic [NS-1:0][47:0] slot_addr;
  logic [NS-1:0]      slot_accept, slot_fc_en;
  logic               pause_accept;
  logic               in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_err = 1'b0;
  logic [7:0]         in_data = '0;
  logic               quantum_tick = 1'b0;
  logic               in_ready, verdict_valid, verdict_fwd, tx_pause;
  logic [15:0]        pause_count;

  mac_ctl_rx_filter #(.N_SLOTS(NS), .QW(16)) u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit started = 0, done_run = 0;
  int tick_div = 0, tcnt = 0;
  bit cur_gap = 0;
  logic [7:0] fr[$];

  // ---------------- reference model ----------------
  logic [7:0] mq[$];
  bit m_rdy = 0, m_vv = 0, m_fwd = 0, m_load = 0, m_blk = 0;
  int m_cnt = 0, m_qv = 0;
  string m_vtag = "R8", m_ctag = "R1";

  always @(posedge clk) begin
    if (!rx_rst_n) begin
      m_rdy = 0; m_vv = 0; m_cnt = 0; mq.delete(); started = 1; m_ctag = "R1";
    end else begin
      if (m_vv && m_load) begin
        m_cnt = m_qv; m_ctag = "R9";
      end else begin
        m_ctag = (m_vv && m_blk) ? "R11" : "R10";
        if (quantum_tick && m_cnt != 0) m_cnt--;
      end
      m_vv = 0;
      if (in_valid && m_rdy) begin
        if (in_sof) mq.delete();
        mq.push_back(in_data);
        if (in_eof) begin
          int len; int sel; int npass; bit fc, ctl, pz;
          len = mq.size(); sel = -1; npass = 0;
          for (int s = 0; s < NS; s++) begin
            bit h; h = (len >= 6) && slot_accept[s];
            for (int k = 0; k < 6 && h; k++)
              if (mq[k] != slot_addr[s][8*(5-k) +: 8]) h = 0;
            if (h) begin npass++; if (sel < 0) sel = s; end
          end
          fc  = (sel >= 0) ? slot_fc_en[sel] : 0;
          ctl = (len >= 18) && mq[12] == 8'h88 && mq[13] == 8'h08;
          pz  = ctl && mq[14] == 8'h00 && mq[15] == 8'h01;
          m_fwd  = (sel >= 0) && !(fc && pz && !pause_accept);
          m_load = (sel >= 0) && fc && pz && !in_err;
          m_blk  = (sel >= 0) && fc && pz && in_err;
          m_qv   = (len >= 18) ? {mq[16], mq[17]} : 0;
          if (sel < 0)            m_vtag = "R2";
          else if (cur_gap)       m_vtag = "R12";
          else if (npass > 1)     m_vtag = "R3";
          else if (in_err)        m_vtag = "R11";
          else if (len < 18)      m_vtag = "R4";
          else if (!fc)           m_vtag = "R7";
          else if (pause_accept)  m_vtag = "R6";
          else                    m_vtag = "R5";
          m_vv = 1;
        end
      end
      m_rdy = 1;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !done_run) begin
      chk("R1", "in_ready", int'(in_ready), int'(m_rdy));
      chk("R8", "verdict_valid", int'(verdict_valid), int'(m_vv));
      if (m_vv) chk(m_vtag, "verdict_fwd", int'(verdict_fwd), int'(m_fwd));
      chk(m_ctag, "pause_count", int'(pause_count), m_cnt);
      chk("R10", "tx_pause", int'(tx_pause), int'(m_cnt != 0));
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    forever begin
      @(negedge clk);
      tcnt++;
      quantum_tick = (tick_div != 0) && (tcnt % tick_div == 0);
    end
  end

  task automatic build(input logic [47:0] da, input logic [15:0] et, input logic [15:0] opc,
                       input logic [15:0] qv, input int len);
    fr.delete();
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      if (i < 6)        b = da[8*(5-i) +: 8];
      else if (i < 12)  b = 8'hA0 + 8'(i);
      else if (i == 12) b = et[15:8];
      else if (i == 13) b = et[7:0];
      else if (i == 14) b = opc[15:8];
      else if (i == 15) b = opc[7:0];
      else if (i == 16) b = qv[15:8];
      else if (i == 17) b = qv[7:0];
      else              b = 8'(i);
      fr.push_back(b);
    end
  endtask

  task automatic send(input bit err, input bit gap, input int idle);
    cur_gap = gap;
    foreach (fr[i]) begin
      if (gap && (i % 3 == 2)) begin
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = fr[i];
      in_sof   = (i == 0);
      in_eof   = (i == fr.size() - 1);
      in_err   = in_eof && err;
      @(negedge clk);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0;
    repeat (idle) @(negedge clk);
  endtask

  localparam logic [47:0] A0 = 48'h0180_C200_0001;
  localparam logic [47:0] A1 = 48'h02AA_BBCC_DDEE;
  localparam logic [15:0] CT = 16'h8808;

  initial begin
    slot_addr[0] = A0; slot_addr[1] = A1;
    slot_accept = 2'b11; slot_fc_en = 2'b01; pause_accept = 1'b0;
    repeat (3) @(negedge clk);
    #(PERIOD/4) rx_rst_n = 1'b1;
    @(negedge clk);
    repeat (2) @(negedge clk);

    // R5/R9: pause on flow-control slot, dropped, timer loaded and held
    build(A0, CT, 16'h0001, 16'h0005, 64); send(0, 0, 5);
    // R10: countdown on every cycle
    tick_div = 1; repeat (8) @(negedge clk);
    // R5: other control opcode forwarded
    build(A0, CT, 16'h0002, 16'h1234, 64); send(0, 0, 3);
    // R9: load then cancel with zero quanta
    tick_div = 0;
    build(A0, CT, 16'h0001, 16'h0030, 60); send(0, 0, 3);
    build(A0, CT, 16'h0001, 16'h0000, 60); send(0, 0, 3);
    // R6: forwarded and still loaded; R10 with slower ticks and load over tick
    pause_accept = 1'b1; tick_div = 3;
    build(A0, CT, 16'h0001, 16'h0100, 60); send(0, 0, 3);
    build(A0, CT, 16'h0001, 16'h0009, 60); send(0, 0, 3);
    // R7: slot 1 has flow control off
    pause_accept = 1'b0;
    build(A1, CT, 16'h0001, 16'h0040, 60); send(0, 0, 3);
    build(A1, 16'h0800, 16'h4500, 16'h0000, 60); send(0, 0, 3);
    // R11: error flag blocks the load only
    tick_div = 0;
    build(A0, CT, 16'h0001, 16'h0077, 60); send(1, 0, 3);
    build(A0, 16'h0800, 16'h0000, 16'h0000, 40); send(1, 0, 3);
    // R2: no match, and a match on a non-accepted slot
    build(48'h0011_2233_4455, CT, 16'h0001, 16'h0050, 60); send(0, 0, 3);
    slot_accept = 2'b10;
    build(A0, CT, 16'h0001, 16'h0050, 60); send(0, 0, 3);
    slot_accept = 2'b11;
    // R3: both slots hold the same address
    slot_addr[1] = A0; slot_fc_en = 2'b10;
    build(A0, CT, 16'h0001, 16'h0022, 60); send(0, 0, 3);
    slot_fc_en = 2'b01;
    build(A0, CT, 16'h0001, 16'h0033, 60); send(0, 0, 3);
    slot_addr[1] = A1;
    // R4: short frames
    build(A0, CT, 16'h0001, 16'h0000, 16); send(0, 0, 3);
    build(A0, CT, 16'h0001, 16'h0000, 17); send(0, 0, 3);
    build(A0, CT, 16'h0001, 16'h0000, 5);  send(0, 0, 3);
    build(A0, CT, 16'h0001, 16'h0000, 1);  send(0, 0, 3);
    // R12: idle gaps inside frames
    build(A0, CT, 16'h0001, 16'h0007, 30); send(0, 1, 3);
    build(A0, CT, 16'h0002, 16'h0000, 30); send(0, 1, 3);
    // R8: back-to-back frames
    tick_div = 2;
    build(A1, 16'h0800, 16'h0000, 16'h0000, 20); send(0, 0, 0);
    build(A0, CT, 16'h0001, 16'h0011, 20); send(0, 0, 0);
    build(A0, CT, 16'h0001, 16'h0004, 18); send(0, 0, 0);
    build(A0, 16'h0800, 16'h0000, 16'h0000, 1); send(0, 0, 0);
    build(A0, CT, 16'h0001, 16'h0020, 18); send(0, 0, 4);
    // R1: receive reset while the timer runs
    tick_div = 0;
    build(A0, CT, 16'h0001, 16'h0020, 18); send(0, 0, 3);
    #(PERIOD/4) rx_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #(PERIOD/4) rx_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    done_run = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_fail++;
    done_run = 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule